// File: doc/BRIEF.md
# Byte FIFO with Fill-Threshold Flag and DMA Request

This block is a byte-wide FIFO that sits between the host side of a serial memory controller and its serial sequencer. Transfers in one direction at a time pass through it. In indirect write the host fills the FIFO one byte per access and the sequencer drains it. In indirect read the sequencer fills it and the host drains it one byte per access. The direction input selects which side pushes and which side pops.

A threshold flag tells the host or a DMA engine that one more group of bytes may move. The threshold comes in as the programmed value minus one. In write direction the flag measures free entries. In read direction it measures stored bytes. It also rises at the tail of a read, once every byte still owed to the host is already in the FIFO. The flag drives a DMA request line when DMA is enabled and an interrupt line when its interrupt enable is set. The flag and the fill level appear in a status word at fixed bit positions.

A host access that cannot complete, a read from an empty FIFO or a write to a full one, is held off with a wait output instead of returning stale data or dropping a byte. An abort empties the FIFO in one cycle.

Top module: `xfifo_top`

## Requirements
- R1: After reset the level is 0. In write direction (dir_rd_i=0) the flag is then 1 for any threshold up to DEPTH, and in read direction it is 0 while remain_i is nonzero.
- R2: In write direction an accepted host write adds one byte and an accepted sequencer pop removes one. The flag is 1 exactly when DEPTH minus level is at least thr_m1_i+1.
- R3: In read direction an accepted sequencer push adds one byte and an accepted host read removes one. The flag is 1 when level is at least thr_m1_i+1.
- R4: In read direction the flag is also 1 when level is nonzero and level is at least remain_i, even if level is below the threshold.
- R5: Bytes leave the FIFO in the order they entered. The head byte is presented on host_rdata_o and seq_rdata_o before it is popped.
- R6: host_wait_o is 1 for a host read in read direction on an empty FIFO and for a host write in write direction on a full FIFO. The stalled access changes nothing, and the level never exceeds DEPTH.
- R7: abort_i empties the FIFO. The level is 0 in the cycle after it, regardless of any push or pop in the same cycle.
- R8: dma_req_o equals the flag ANDed with dma_en_i.
- R9: thr_irq_o equals the flag ANDed with thr_ie_i.
- R10: status_o carries the flag at bit 2 and the level zero-extended in bits 13:8. All other bits are 0.
- R11: A host write in read direction, and a sequencer push in write direction, leave the level and contents unchanged.
- R12: A push and a pop accepted in the same cycle leave the level unchanged. The level moves by at most one per cycle unless an abort occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_rd_i | input | 1 | 1 selects indirect read, 0 selects indirect write |
| thr_m1_i | input | $clog2(DEPTH) | Threshold minus one |
| dma_en_i | input | 1 | Enables the DMA request |
| thr_ie_i | input | 1 | Enables the threshold interrupt |
| abort_i | input | 1 | Flushes the FIFO |
| remain_i | input | CW | Bytes of the current read not yet taken by the host |
| host_wr_i | input | 1 | Host byte write to the data register |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host byte read from the data register |
| host_rdata_o | output | 8 | Head byte returned to the host |
| host_wait_o | output | 1 | Host access stalled |
| seq_push_i | input | 1 | Sequencer stores a received byte |
| seq_wdata_i | input | 8 | Sequencer byte to store |
| seq_pop_i | input | 1 | Sequencer takes a byte to send |
| seq_rdata_o | output | 8 | Head byte offered to the sequencer |
| seq_ok_o | output | 1 | Sequencer side may push (read) or pop (write) |
| status_o | output | 16 | Flag at bit 2, level at bits 13:8 |
| thr_irq_o | output | 1 | Threshold interrupt |
| dma_req_o | output | 1 | DMA request |

## Verification
The bench builds the block with DEPTH=8 and an 8-bit remain count. A short random run then reaches both the full and the empty boundary often. It also meets every threshold value from 1 to DEPTH, including the one equal to DEPTH. The small remain width lets random tails fall below, at and above the level, so the tail condition of the read flag gets exercised. Direction switches are made with data still in the FIFO, which tests the ignored-access rules.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int STAT_W        = 16;
  localparam int STAT_FLAG_BIT = 2;
  localparam int STAT_LVL_LSB  = 8;
  localparam int STAT_LVL_W    = 6;
  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} xdir_e;
endpackage

// File: rtl/xfifo_store.sv
module xfifo_store #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [7:0]    pdata_i,
  input  logic          pop_i,
  output logic [7:0]    head_o,
  output logic [LW-1:0] level_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_ptr] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign level_o = level;
endmodule

// File: rtl/xfifo_thr.sv
module xfifo_thr #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int TW    = $clog2(DEPTH),
  parameter int CW    = 16
) (
  input  logic [LW-1:0] level_i,
  input  logic [TW-1:0] thr_m1_i,
  input  logic          rd_mode_i,
  input  logic [CW-1:0] remain_i,
  output logic          flag_o
);
  logic [LW-1:0] thr, free;
  logic          tail;

  always_comb begin
    thr  = LW'(thr_m1_i) + 1'b1;
    free = LW'(DEPTH) - level_i;
    // read tail: everything still owed is already stored
    tail = (level_i != '0) && (CW'(level_i) >= remain_i);
    if (rd_mode_i) flag_o = (level_i >= thr) || tail;
    else           flag_o = (free >= thr);
  end
endmodule

// File: rtl/xfifo_top.sv
module xfifo_top
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = 16,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rd_i,
  input  logic [TW-1:0]     thr_m1_i,
  input  logic              dma_en_i,
  input  logic              thr_ie_i,
  input  logic              abort_i,
  input  logic [CW-1:0]     remain_i,
  input  logic              host_wr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              host_rd_i,
  output logic [7:0]        host_rdata_o,
  output logic              host_wait_o,
  input  logic              seq_push_i,
  input  logic [7:0]        seq_wdata_i,
  input  logic              seq_pop_i,
  output logic [7:0]        seq_rdata_o,
  output logic              seq_ok_o,
  output logic [STAT_W-1:0] status_o,
  output logic              thr_irq_o,
  output logic              dma_req_o
);
  xdir_e         dir;
  logic [LW-1:0] level;
  logic [7:0]    head, pdata;
  logic          full, empty, push, pop, flag;

  assign dir   = xdir_e'(dir_rd_i);
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  always_comb begin
    if (dir == DIR_READ) begin
      push        = seq_push_i & ~full;
      pdata       = seq_wdata_i;
      pop         = host_rd_i & ~empty;
      host_wait_o = host_rd_i & empty;
      seq_ok_o    = ~full;
    end else begin
      push        = host_wr_i & ~full;
      pdata       = host_wdata_i;
      pop         = seq_pop_i & ~empty;
      host_wait_o = host_wr_i & full;
      seq_ok_o    = ~empty;
    end
  end

  xfifo_store #(.DEPTH(DEPTH), .LW(LW)) u_store (
    .clk_i, .rst_ni,
    .flush_i (abort_i),
    .push_i  (push),
    .pdata_i (pdata),
    .pop_i   (pop),
    .head_o  (head),
    .level_o (level)
  );

  xfifo_thr #(.DEPTH(DEPTH), .LW(LW), .TW(TW), .CW(CW)) u_thr (
    .level_i   (level),
    .thr_m1_i  (thr_m1_i),
    .rd_mode_i (dir == DIR_READ),
    .remain_i  (remain_i),
    .flag_o    (flag)
  );

  assign host_rdata_o = head;
  assign seq_rdata_o  = head;
  assign dma_req_o    = flag & dma_en_i;
  assign thr_irq_o    = flag & thr_ie_i;

  always_comb begin
    status_o = '0;
    status_o[STAT_FLAG_BIT] = flag;
    status_o[STAT_LVL_LSB +: STAT_LVL_W] = STAT_LVL_W'(level);
  end
endmodule

// File: rtl/xfifo_chk.sv
module xfifo_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        dir_rd_i,
  input logic        dma_en_i,
  input logic        abort_i,
  input logic        host_rd_i,
  input logic        host_wait_o,
  input logic [15:0] status_o,
  input logic        dma_req_o
);
  logic [5:0] lvl;
  assign lvl = status_o[13:8];

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(lvl) <= DEPTH); // R6
  AST_WAIT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rd_i && lvl == 0 && host_rd_i) |-> host_wait_o); // R6
  AST_ABORT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (lvl == 0)); // R7
  AST_DMA_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (dma_en_i && status_o[2])); // R8
  AST_STAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1:0] == 0 && status_o[7:3] == 0 && status_o[15:14] == 0)); // R10
  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(abort_i) |-> (int'(lvl) <= int'($past(lvl)) + 1 &&
                         int'(lvl) + 1 >= int'($past(lvl)))); // R12
endmodule

bind xfifo_top xfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dir_rd_i(dir_rd_i), .dma_en_i(dma_en_i),
  .abort_i(abort_i), .host_rd_i(host_rd_i), .host_wait_o(host_wait_o),
  .status_o(status_o), .dma_req_o(dma_req_o)
);

// File: tb/xfifo_top_tb.sv
module xfifo_top_tb;
  localparam int DEPTH = 8;
  localparam int CW    = 8;
  localparam int TW    = $clog2(DEPTH);

  logic          clk = 0, rst_ni = 0;
  logic          dir_rd = 0, dma_en = 0, thr_ie = 0, abort = 0;
  logic [TW-1:0] thr_m1 = 3;
  logic [CW-1:0] remain = 0;
  logic          host_wr = 0, host_rd = 0, seq_push = 0, seq_pop = 0;
  logic [7:0]    host_wdata = 0, seq_wdata = 0;
  logic [7:0]    host_rdata, seq_rdata;
  logic          host_wait, seq_ok, thr_irq, dma_req;
  logic [15:0]   status;

  int errors = 0, checks = 0;
  bit done = 0;
  int mq[$];

  always #10 clk = ~clk;

  xfifo_top #(.DEPTH(DEPTH), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .dir_rd_i(dir_rd), .thr_m1_i(thr_m1),
    .dma_en_i(dma_en), .thr_ie_i(thr_ie), .abort_i(abort), .remain_i(remain),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd),
    .host_rdata_o(host_rdata), .host_wait_o(host_wait),
    .seq_push_i(seq_push), .seq_wdata_i(seq_wdata), .seq_pop_i(seq_pop),
    .seq_rdata_o(seq_rdata), .seq_ok_o(seq_ok), .status_o(status),
    .thr_irq_o(thr_irq), .dma_req_o(dma_req)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FIFO-BENCH FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_flag(bit rd, int t1, int rem, int lvl);
    int thr = t1 + 1;
    if (rd) return (lvl >= thr) || (lvl != 0 && lvl >= rem);
    return (DEPTH - lvl) >= thr;
  endfunction

  task automatic check_outputs();
    bit f = exp_flag(dir_rd, int'(thr_m1), int'(remain), mq.size());
    chk("R2/R3 level", int'(status[13:8]), mq.size());
    chk(dir_rd ? "R3/R4 flag" : "R2 flag", int'(status[2]), int'(f));
    chk("R8 dma_req", int'(dma_req), int'(f & dma_en));
    chk("R9 thr_irq", int'(thr_irq), int'(f & thr_ie));
    chk("R10 spare bits", int'({status[15:14], status[7:3], status[1:0]}), 0);
  endtask

  // one cycle: drive at negedge, check combinational outputs, then state after the edge
  task automatic cyc(bit hw, bit hr, bit sp, bit sq, bit ab, logic [7:0] wd, logic [7:0] sd);
    bit full, empty, push, pop;
    @(negedge clk);
    host_wr = hw; host_rd = hr; seq_push = sp; seq_pop = sq; abort = ab;
    host_wdata = wd; seq_wdata = sd;
    #1;
    full  = (mq.size() == DEPTH);
    empty = (mq.size() == 0);
    if (dir_rd) begin
      chk("R6 wait rd", int'(host_wait), int'(hr & empty));
      push = sp & ~full; pop = hr & ~empty;
      if (pop) chk("R5 host order", int'(host_rdata), mq[0]);
    end else begin
      chk("R6 wait wr", int'(host_wait), int'(hw & full));
      push = hw & ~full; pop = sq & ~empty;
      if (pop) chk("R5 seq order", int'(seq_rdata), mq[0]);
    end
    if (ab) mq.delete();
    else begin
      if (pop) void'(mq.pop_front());
      if (push) mq.push_back(int'(dir_rd ? sd : wd));
    end
    @(posedge clk); #2;
    host_wr = 0; host_rd = 0; seq_push = 0; seq_pop = 0; abort = 0;
    check_outputs();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FIFO-BENCH FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state, write direction
    chk("R1 level", int'(status[13:8]), 0);
    chk("R1 flag wr", int'(status[2]), 1);
    rst_ni = 1;
    dir_rd = 1; remain = 5; #1;
    chk("R1 flag rd", int'(status[2]), 0);
    dir_rd = 0;
    // R2 fill to full in write direction, threshold 4
    dma_en = 1; thr_ie = 1; thr_m1 = 3;
    for (int i = 0; i < DEPTH; i++) cyc(1, 0, 0, 0, 0, 8'(8'h40 + i), 0);
    chk("R2 full level", int'(status[13:8]), DEPTH);
    chk("R2 flag at full", int'(status[2]), 0);
    cyc(1, 0, 0, 0, 0, 8'hEE, 0);   // R6 write to full stalls
    cyc(0, 0, 1, 0, 0, 0, 8'h11);   // R11 seq push in write dir ignored
    chk("R11 level", int'(status[13:8]), DEPTH);
    cyc(1, 0, 0, 1, 0, 8'hEE, 0);   // full: pop accepted, push stalled
    cyc(1, 0, 0, 1, 0, 8'h50, 0);   // R12 push+pop
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1, 0, 0, 0);  // R5 drain
    // R7 abort with data inside
    cyc(1, 0, 0, 0, 0, 8'h01, 0);
    cyc(1, 0, 0, 0, 0, 8'h02, 0);
    cyc(1, 0, 0, 1, 1, 8'h03, 0);
    chk("R7 flushed", int'(status[13:8]), 0);
    // R3/R4 read direction
    dir_rd = 1; thr_m1 = 3; remain = 20;
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, 0, 8'(8'h80 + i));
    cyc(1, 0, 0, 0, 0, 8'hAA, 0);   // R11 host write in read dir ignored
    chk("R11 rd level", int'(status[13:8]), 5);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, 0, 0);
    remain = 2; #1;
    chk("R4 tail flag", int'(status[2]), 1);
    remain = 3; #1;
    chk("R4 tail above level", int'(status[2]), 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, 0, 0);   // R6 last read stalls
    // randomized phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if ($urandom_range(0, 49) == 0) dir_rd = ~dir_rd;
      thr_m1 = TW'($urandom_range(0, DEPTH - 1));
      remain = CW'($urandom_range(0, 12));
      dma_en = 1'($urandom); thr_ie = 1'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          $urandom_range(0, 60) == 0, 8'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule